// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is an 18-bit first-in first-out buffer. The producer and the consumer run on separate, unrelated clocks. Words go into a dual-port storage array under an active-low write enable on the write clock. They come out through a registered output stage under an active-low read enable on the read clock. The depth is a power-of-two parameter from 64 to 4096 words.

Five active-low status flags report the fill state: empty, full, half-full, almost-empty and almost-full. The two almost thresholds are offset values that a separate loader block provides, and they can change at run time. The read and write pointers cross between the clock domains in Gray code. Flags about the write side are formed in the write clock domain, and flags about the read side are formed in the read clock domain. A write is dropped when the buffer is full. A read is dropped when it is empty, and the output register then keeps the last word that was really read.

An output-enable input controls a drive indication that stands in for a tri-state output. When the output is not enabled, the data port shows zero.

Top module: `dcfifo_pf`

## Requirements
- R1: With `wr_en_n` low and `full_n` high at a rising `wr_clk` edge, `wr_data` is stored. Stored words leave the buffer in the order they were written.
- R2: With `rd_en_n` low and `empty_n` high at a rising `rd_clk` edge, the oldest stored word is loaded into the output register at that edge.
- R3: A write attempted while `full_n` is low stores nothing. The words already held are unchanged.
- R4: A read attempted while `empty_n` is low does not move the read pointer. The output keeps the word from the last accepted read.
- R5: While `rst_n` is low, the buffer is empty and the output register is zero. In this state `empty_n` and `almost_empty_n` are low, and `full_n`, `half_full_n` and `almost_full_n` are high. Read and write attempts made during reset are not accepted.
- R6: Once the pointers have settled, `almost_empty_n` is low exactly when the stored word count is less than or equal to `ae_ofs`.
- R7: Once the pointers have settled, `almost_full_n` is low exactly when the free space (DEPTH minus count) is less than or equal to `af_ofs`.
- R8: Once the pointers have settled, `half_full_n` is low exactly when the count is greater than DEPTH/2.
- R9: With `oe_n` high, `rd_drive` is low and `rd_data` reads zero. With `oe_n` low, `rd_drive` is high and `rd_data` shows the output register. Toggling `oe_n` does not change the output register.
- R10: Once the pointers have settled, `empty_n` is low exactly when the count is zero, and `full_n` is low exactly when the count equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | 18 | Word to store |
| rd_en_n | input | 1 | Active-low read request |
| oe_n | input | 1 | Active-low output enable |
| ae_ofs | input | OFS_W | Almost-empty threshold in words |
| af_ofs | input | OFS_W | Almost-full threshold in free words |
| rd_data | output | 18 | Output register value, zero when not enabled |
| rd_drive | output | 1 | High when the output would drive the bus |
| empty_n | output | 1 | Low when no words are stored (read domain) |
| almost_empty_n | output | 1 | Low when the count is at or below `ae_ofs` (read domain) |
| half_full_n | output | 1 | Low when the count is above DEPTH/2 (write domain) |
| almost_full_n | output | 1 | Low when the free space is at or below `af_ofs` (write domain) |
| full_n | output | 1 | Low when DEPTH words are stored (write domain) |

## Verification
A wrong pointer shows up in one of two ways. One is a data word that arrives out of order, is repeated, or belongs to an overflow write; this appears in the first read burst that drains past the fault. The other is a flag pattern that disagrees with the known fill level a few clocks after traffic stops. The stimulus brings the fill level exactly onto each threshold and one word past it, so a comparison off by one shows in that settle window. It also reads past empty and writes past full, so an unguarded pointer wraps and corrupts the next drained sequence. It then resets with traffic still requested.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;
   localparam int DATA_W = 18;

   typedef logic [DATA_W-1:0] word_t;

   // How the almost flags reach their ports
   typedef enum logic {
      ALM_COMB = 1'b0,   // straight from the pointer difference
      ALM_REG  = 1'b1    // one register stage in the owning clock domain
   } almost_mode_e;
endpackage

// File: rtl/fifo_pf_gray_sync.sv
// Two-stage synchroniser for a Gray-coded pointer, with binary output
module fifo_pf_gray_sync #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);
   logic [W-1:0] meta_q, stab_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         stab_q <= '0;
      end else begin
         meta_q <= gray_in;
         stab_q <= meta_q;
      end
   end

   always_comb begin
      for (int i = 0; i < W; i++) begin
         bin_out[i] = ^(stab_q >> i);
      end
   end
endmodule

// File: rtl/fifo_pf_ram.sv
// Storage array with a registered, resettable read port
module fifo_pf_ram
   import fifo_pf_pkg::*;
#(
   parameter  int DEPTH = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          wr_clk,
   input  logic          wr_en,
   input  logic [AW-1:0] waddr,
   input  word_t         wdata,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] raddr,
   output word_t         rd_q
);
   word_t mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (wr_en) mem[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= mem[raddr];
   end
endmodule

// File: rtl/fifo_pf_wr_side.sv
// Write pointer, full, half-full and almost-full flags (write domain)
module fifo_pf_wr_side
   import fifo_pf_pkg::*;
#(
   parameter  int           DEPTH       = 64,
   parameter  int           OFS_W       = 12,
   parameter  almost_mode_e ALMOST_MODE = ALM_REG,
   localparam int           AW          = $clog2(DEPTH),
   localparam int           PTR_W       = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_n,
   input  logic [OFS_W-1:0] af_ofs,
   input  logic [PTR_W-1:0] rbin_sync,
   output logic             wr_acc,
   output logic [AW-1:0]    waddr,
   output logic [PTR_W-1:0] wgray,
   output logic             full_n,
   output logic             half_full_n,
   output logic             almost_full_n
);
   localparam int CMP_W = (OFS_W > PTR_W) ? OFS_W : PTR_W;

   logic [PTR_W-1:0] wbin_q, wnext, wcount;
   logic             is_full, af_hit;

   assign wcount  = wbin_q - rbin_sync;
   assign is_full = (wcount == PTR_W'(DEPTH));
   assign wr_acc  = rst_n & ~wr_en_n & ~is_full;
   assign wnext   = wbin_q + PTR_W'(1);
   assign waddr   = wbin_q[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin_q <= '0;
         wgray  <= '0;
      end else if (wr_acc) begin
         wbin_q <= wnext;
         wgray  <= wnext ^ (wnext >> 1);
      end
   end

   assign full_n      = ~is_full;
   assign half_full_n = ~(wcount > PTR_W'(DEPTH / 2));
   assign af_hit      = CMP_W'(PTR_W'(DEPTH) - wcount) <= CMP_W'(af_ofs);

   if (ALMOST_MODE == ALM_REG) begin : g_af_reg
      logic af_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) af_q <= 1'b1;
         else        af_q <= ~af_hit;
      end
      assign almost_full_n = af_q;
   end else begin : g_af_comb
      assign almost_full_n = ~af_hit;
   end

   // R3: the write side never counts past a full buffer
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      wcount <= PTR_W'(DEPTH));
   // R1: an accepted write advances the pointer by exactly one
   a_r1_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> wbin_q == $past(wbin_q) + PTR_W'(1));
   // R1: the crossing pointer changes at most one bit per edge
   a_r1_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);
   // R8: a full buffer is also above half
   a_r8_full_is_half: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> !half_full_n);
endmodule

// File: rtl/fifo_pf_rd_side.sv
// Read pointer, empty and almost-empty flags (read domain)
module fifo_pf_rd_side
   import fifo_pf_pkg::*;
#(
   parameter  int           DEPTH       = 64,
   parameter  int           OFS_W       = 12,
   parameter  almost_mode_e ALMOST_MODE = ALM_REG,
   localparam int           AW          = $clog2(DEPTH),
   localparam int           PTR_W       = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en_n,
   input  logic [OFS_W-1:0] ae_ofs,
   input  logic [PTR_W-1:0] wbin_sync,
   output logic             rd_acc,
   output logic [AW-1:0]    raddr,
   output logic [PTR_W-1:0] rgray,
   output logic             empty_n,
   output logic             almost_empty_n
);
   localparam int CMP_W = (OFS_W > PTR_W) ? OFS_W : PTR_W;

   logic [PTR_W-1:0] rbin_q, rnext, rcount;
   logic             is_empty, ae_hit;

   assign rcount   = wbin_sync - rbin_q;
   assign is_empty = (rcount == '0);
   assign rd_acc   = rst_n & ~rd_en_n & ~is_empty;
   assign rnext    = rbin_q + PTR_W'(1);
   assign raddr    = rbin_q[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin_q <= '0;
         rgray  <= '0;
      end else if (rd_acc) begin
         rbin_q <= rnext;
         rgray  <= rnext ^ (rnext >> 1);
      end
   end

   assign empty_n = ~is_empty;
   assign ae_hit  = CMP_W'(rcount) <= CMP_W'(ae_ofs);

   if (ALMOST_MODE == ALM_REG) begin : g_ae_reg
      logic ae_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ae_q <= 1'b0;
         else        ae_q <= ~ae_hit;
      end
      assign almost_empty_n = ae_q;
   end else begin : g_ae_comb
      assign almost_empty_n = ~ae_hit;
   end

   // R4: the read pointer never passes the synchronised write pointer
   a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      rcount <= PTR_W'(DEPTH));
   // R2: an accepted read advances the pointer by exactly one
   a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> rbin_q == $past(rbin_q) + PTR_W'(1));
   // R2: the crossing pointer changes at most one bit per edge
   a_r2_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcfifo_pf.sv
module dcfifo_pf
   import fifo_pf_pkg::*;
#(
   parameter int           DEPTH       = 64,
   parameter int           OFS_W       = 12,
   parameter almost_mode_e ALMOST_MODE = ALM_REG
) (
   input  logic             wr_clk,
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic             wr_en_n,
   input  logic [17:0]      wr_data,
   input  logic             rd_en_n,
   input  logic             oe_n,
   input  logic [OFS_W-1:0] ae_ofs,
   input  logic [OFS_W-1:0] af_ofs,
   output logic [17:0]      rd_data,
   output logic             rd_drive,
   output logic             empty_n,
   output logic             almost_empty_n,
   output logic             half_full_n,
   output logic             almost_full_n,
   output logic             full_n
);
   localparam int AW    = $clog2(DEPTH);
   localparam int PTR_W = AW + 1;

   if (DEPTH < 64 || DEPTH > 4096 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dcfifo_pf: DEPTH must be a power of two from 64 to 4096");
   end
   if (OFS_W < 1 || OFS_W > 16) begin : g_bad_ofs
      $error("dcfifo_pf: OFS_W must be 1 to 16");
   end
   if (DATA_W != 18) begin : g_bad_data
      $error("dcfifo_pf: package word width must be 18");
   end

   logic             wr_acc, rd_acc;
   logic [AW-1:0]    waddr, raddr;
   logic [PTR_W-1:0] wgray, rgray, wbin_rs, rbin_ws;
   word_t            rd_q;

   fifo_pf_wr_side #(.DEPTH(DEPTH), .OFS_W(OFS_W), .ALMOST_MODE(ALMOST_MODE)) wr_side_i (
      .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .af_ofs(af_ofs),
      .rbin_sync(rbin_ws), .wr_acc(wr_acc), .waddr(waddr), .wgray(wgray),
      .full_n(full_n), .half_full_n(half_full_n), .almost_full_n(almost_full_n)
   );

   fifo_pf_rd_side #(.DEPTH(DEPTH), .OFS_W(OFS_W), .ALMOST_MODE(ALMOST_MODE)) rd_side_i (
      .clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .ae_ofs(ae_ofs),
      .wbin_sync(wbin_rs), .rd_acc(rd_acc), .raddr(raddr), .rgray(rgray),
      .empty_n(empty_n), .almost_empty_n(almost_empty_n)
   );

   fifo_pf_gray_sync #(.W(PTR_W)) w2r_i (
      .clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_rs)
   );

   fifo_pf_gray_sync #(.W(PTR_W)) r2w_i (
      .clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_ws)
   );

   fifo_pf_ram #(.DEPTH(DEPTH)) ram_i (
      .wr_clk(wr_clk), .wr_en(wr_acc), .waddr(waddr), .wdata(wr_data),
      .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_acc), .raddr(raddr), .rd_q(rd_q)
   );

   assign rd_drive = ~oe_n;
   assign rd_data  = oe_n ? '0 : rd_q;

   // R4: a read request on an empty buffer leaves the output register alone
   a_r4_hold_last: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!rd_en_n && !empty_n) |=> $stable(rd_q));
   // R9: a disabled output never shows data
   a_r9_quiet_when_off: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !rd_drive |-> rd_data == '0);
endmodule

// File: tb/dcfifo_pf_tb_top.sv
`timescale 1ns/1ps
module dcfifo_pf_tb_top;
   localparam int DEPTH = 64;
   localparam int OFS_W = 12;

   logic             wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic             wr_en_n = 1'b1, rd_en_n = 1'b1, oe_n = 1'b0;
   logic [17:0]      wr_data = '0;
   logic [OFS_W-1:0] ae_ofs = 12'd8, af_ofs = 12'd10;
   logic [17:0]      rd_data;
   logic             rd_drive, empty_n, almost_empty_n, half_full_n, almost_full_n, full_n;

   int          checks = 0, failures = 0;
   logic [17:0] model [DEPTH];
   int          mhead = 0, mtail = 0, mcount = 0;
   logic [17:0] wdat = 18'h00100, last = '0;

   dcfifo_pf #(.DEPTH(DEPTH), .OFS_W(OFS_W)) dut_i (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
      .wr_data(wr_data), .rd_en_n(rd_en_n), .oe_n(oe_n), .ae_ofs(ae_ofs),
      .af_ofs(af_ofs), .rd_data(rd_data), .rd_drive(rd_drive), .empty_n(empty_n),
      .almost_empty_n(almost_empty_n), .half_full_n(half_full_n),
      .almost_full_n(almost_full_n), .full_n(full_n)
   );

   always #4 wr_clk = ~wr_clk;
   initial begin
      #1.5;
      forever #4 rd_clk = ~rd_clk;
   end

   // {is_read, burst length, expected fill level afterwards}
   localparam int NV = 14;
   localparam logic [16:0] VEC [NV] = '{
      {1'b0, 8'd5,  8'd5},   {1'b1, 8'd2,  8'd3},   {1'b0, 8'd5,  8'd8},
      {1'b0, 8'd1,  8'd9},   {1'b0, 8'd23, 8'd32},  {1'b0, 8'd1,  8'd33},
      {1'b0, 8'd40, 8'd64},  {1'b1, 8'd10, 8'd54},  {1'b1, 8'd1,  8'd53},
      {1'b0, 8'd3,  8'd56},  {1'b1, 8'd56, 8'd0},   {1'b1, 8'd4,  8'd0},
      {1'b0, 8'd20, 8'd20},  {1'b1, 8'd20, 8'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge wr_clk);
      repeat (6) @(negedge rd_clk);
      @(negedge wr_clk);
   endtask

   task automatic check_flags(input int c);
      chk("R10 empty_n", 32'(empty_n), 32'(c != 0));
      chk("R10 full_n", 32'(full_n), 32'(c != DEPTH));
      chk("R8 half_full_n", 32'(half_full_n), 32'(!(c > DEPTH / 2)));
      chk("R6 almost_empty_n", 32'(almost_empty_n), 32'(!(c <= int'(ae_ofs))));
      chk("R7 almost_full_n", 32'(almost_full_n), 32'(!((DEPTH - c) <= int'(af_ofs))));
   endtask

   task automatic do_write(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge wr_clk);
         wr_en_n = 1'b0;
         wr_data = wdat;
         if (mcount < DEPTH) begin  // R3: writes past full are dropped
            model[mtail] = wdat;
            mtail = (mtail + 1) % DEPTH;
            mcount++;
         end
         wdat++;
      end
      @(negedge wr_clk);
      wr_en_n = 1'b1;
   endtask

   task automatic do_read(input int n);
      @(negedge rd_clk);
      rd_en_n = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge rd_clk);
         if (mcount > 0) begin
            last = model[mhead];
            mhead = (mhead + 1) % DEPTH;
            mcount--;
            chk("R2 read data in order", 32'(rd_data), 32'(last));
         end else begin
            chk("R4 data held on empty read", 32'(rd_data), 32'(last));
         end
         if (i == n - 1) rd_en_n = 1'b1;
      end
   endtask

   initial begin
      #(200000 * 8);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R5: state during reset
      repeat (5) @(negedge wr_clk);
      chk("R5 reset rd_data", 32'(rd_data), 32'h0);
      chk("R5 reset rd_drive", 32'(rd_drive), 32'h1);
      check_flags(0);
      rst_n = 1'b1;
      settle();

      // Table-driven traffic
      for (int v = 0; v < NV; v++) begin
         if (VEC[v][16]) do_read(int'(VEC[v][15:8]));
         else            do_write(int'(VEC[v][15:8]));
         settle();
         check_flags(int'(VEC[v][7:0]));
         if (v == 6) chk("R3 full after overflow burst", 32'(full_n), 32'h0);
      end

      // R9: output enable masks the data, the register is kept
      oe_n = 1'b1;
      #1;
      chk("R9 drive off", 32'(rd_drive), 32'h0);
      chk("R9 data masked", 32'(rd_data), 32'h0);
      oe_n = 1'b0;
      #1;
      chk("R9 drive on", 32'(rd_drive), 32'h1);
      chk("R9 data restored", 32'(rd_data), 32'(last));

      // R6, R7: thresholds changed at run time
      ae_offset_change();
      do_write(30);
      settle();
      check_flags(30);
      do_write(31);
      settle();
      check_flags(61);
      do_write(2);
      settle();
      check_flags(63);

      // R5: reset with traffic requested, nothing accepted during it
      @(negedge wr_clk);
      rst_n = 1'b0;
      wr_en_n = 1'b0;
      rd_en_n = 1'b0;
      repeat (4) @(negedge wr_clk);
      chk("R5 mid reset rd_data", 32'(rd_data), 32'h0);
      check_flags(0);
      wr_en_n = 1'b1;
      rd_en_n = 1'b1;
      @(negedge wr_clk);
      rst_n = 1'b1;
      mhead = 0; mtail = 0; mcount = 0; last = '0;
      settle();
      chk("R5 empty after reset", 32'(empty_n), 32'h0);
      check_flags(0);
      do_read(1);

      // R1: order after reset
      do_write(3);
      settle();
      check_flags(3);
      do_read(3);
      settle();
      check_flags(0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic ae_offset_change();
      @(negedge wr_clk);
      ae_ofs = 12'd25;
      af_ofs = 12'd3;
   endtask
endmodule